// File: doc/BRIEF.md
# Split-Sub-Tag Associative Tag Store

This block is a small fully associative tag store whose entries can be searched in parallel by key. Each entry does not keep its tag as one word. It keeps two sub-tags of half the tag width each. One sub-tag is the lower half of the tag, unchanged. The other is the bitwise XOR of the upper half with the lower half. A search key is split and encoded in the same way, and each half is compared against its own sub-tag bank across all valid entries. Both comparisons are needed to report a hit. Because the upper half can be rebuilt by XORing the two stored sub-tags, no tag information is lost.

When a valid entry agrees with the key in only one of the two banks, and no entry agrees in both, the store becomes busy for one extra cycle. In that cycle it rebuilds the full stored tag of the lowest such entry and compares it against the whole key. The outcome is a true miss or a recovered hit. The result is flagged as coming from this backup check. A combinational read-back port returns the rebuilt tag and the valid bit of any entry. Writes set or clear an entry's valid bit together with its tag.

Top module: `split_tag_cam`

## Requirements
- R1: After reset every entry reads back with rd_valid = 0 and rd_tag = 0, and busy and rsp_valid are 0.
- R2: A write with wr_en = 1 stores wr_tag and wr_valid into entry wr_idx at the clock edge. From then on, rd_tag for that index returns exactly wr_tag and rd_valid returns wr_valid.
- R3: An entry agrees with a key in the low bank when tag[7:0] equals key[7:0]. It agrees in the mixed bank when tag[15:8]^tag[7:0] equals key[15:8]^key[7:0].
- R4: An accepted search in which at least one valid entry agrees in both banks raises rsp_valid one cycle later, with rsp_hit = 1, rsp_backup = 0 and rsp_idx equal to the lowest such entry index. busy stays 0.
- R5: An accepted search with no full agreement, but with a valid entry that agrees in exactly one bank, raises busy for exactly the next cycle with rsp_valid = 0. The cycle after that gives rsp_valid = 1 and rsp_backup = 1, with rsp_idx set to the lowest partially agreeing entry. rsp_hit is 1 only if that entry's rebuilt tag equals the key, which cannot happen with intact storage.
- R6: An accepted search with no agreement in either bank raises rsp_valid one cycle later with rsp_hit = 0, rsp_backup = 0 and rsp_idx = 0.
- R7: Entries whose valid bit is 0 never take part in a full or a partial agreement.
- R8: srch_en asserted while busy = 1 is ignored. Only the backup response follows, and no further response is produced for the ignored key.
- R9: A write with wr_valid = 0 removes the entry from all later searches.
- R10: rsp_valid is a one-cycle pulse, produced once per accepted search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Entry written |
| wr_tag | input | 16 | Tag written |
| wr_valid | input | 1 | Valid bit written with the tag |
| srch_en | input | 1 | Search strobe (ignored while busy) |
| srch_key | input | 16 | Search key |
| busy | output | 1 | Backup check cycle in progress |
| rsp_valid | output | 1 | Search result pulse |
| rsp_hit | output | 1 | Search found the key |
| rsp_idx | output | 4 | Matching or checked entry index |
| rsp_backup | output | 1 | Result came from the backup check |
| rd_idx | input | 4 | Entry to read back |
| rd_tag | output | 16 | Rebuilt full tag of entry rd_idx |
| rd_valid | output | 1 | Valid bit of entry rd_idx |

## Verification
On every cycle, the assertions check the response timing in its three forms: one-cycle response after a full or empty search, busy lasting exactly one cycle, and busy always followed by a backup-flagged response. They also check that a backup response never reports a hit while storage is intact, and that a search offered during busy produces no extra pulse. The bench scenarios are what show that the hit index is the lowest full match and that each bank encoding decides which entries count as partial. They also show that invalidated entries drop out entirely and that read-back rebuilds the written tag exactly.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FULL = 2'd1,
    CLS_PART = 2'd2
  } search_cls_e;
endpackage

// File: rtl/stc_bank.sv
module stc_bank #(
  parameter int ENTRIES = 16,
  parameter int HALF_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [HALF_W-1:0]              wr_lo,
  input  logic [HALF_W-1:0]              wr_mix,
  input  logic                           wr_valid,
  input  logic [HALF_W-1:0]              key_lo,
  input  logic [HALF_W-1:0]              key_mix,
  output logic [ENTRIES-1:0]             agree_lo,
  output logic [ENTRIES-1:0]             agree_mix,
  output logic [ENTRIES-1:0][HALF_W-1:0] st_lo,
  output logic [ENTRIES-1:0][HALF_W-1:0] st_mix,
  output logic [ENTRIES-1:0]             st_valid
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic              v_q;
    logic [HALF_W-1:0] lo_q, mix_q;
    wire               sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        lo_q  <= '0;
        mix_q <= '0;
      end else if (sel) begin
        v_q   <= wr_valid;
        lo_q  <= wr_lo;
        mix_q <= wr_mix;
      end
    end

    assign agree_lo[e]  = v_q && (lo_q  == key_lo);
    assign agree_mix[e] = v_q && (mix_q == key_mix);
    assign st_lo[e]     = lo_q;
    assign st_mix[e]    = mix_q;
    assign st_valid[e]  = v_q;
  end
endmodule

// File: rtl/stc_first_set.sv
module stc_first_set #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/split_tag_cam.sv
module split_tag_cam
  import stc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 16,
  localparam int HALF_W = TAG_W / 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             srch_en,
  input  logic [TAG_W-1:0] srch_key,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             rsp_backup,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  function automatic logic [HALF_W-1:0] sub_low(input logic [TAG_W-1:0] t);
    return t[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] sub_mix(input logic [TAG_W-1:0] t);
    return t[TAG_W-1:HALF_W] ^ t[HALF_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] rebuild(input logic [HALF_W-1:0] lo,
                                               input logic [HALF_W-1:0] mix);
    return {mix ^ lo, lo};
  endfunction

  logic [ENTRIES-1:0]             agree_lo, agree_mix, st_valid;
  logic [ENTRIES-1:0][HALF_W-1:0] st_lo, st_mix;

  stc_bank #(.ENTRIES(ENTRIES), .HALF_W(HALF_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lo(sub_low(wr_tag)), .wr_mix(sub_mix(wr_tag)), .wr_valid(wr_valid),
    .key_lo(sub_low(srch_key)), .key_mix(sub_mix(srch_key)),
    .agree_lo(agree_lo), .agree_mix(agree_mix),
    .st_lo(st_lo), .st_mix(st_mix), .st_valid(st_valid)
  );

  // Named internal events, used by the checker.
  logic [ENTRIES-1:0] full_vec, part_vec;
  logic               any_full, any_part;
  logic [IDX_W-1:0]   full_idx, part_idx;
  logic               accept;
  search_cls_e        cls;

  assign full_vec = agree_lo & agree_mix;
  assign part_vec = agree_lo ^ agree_mix;

  stc_first_set #(.N(ENTRIES)) u_full (.vec(full_vec), .any(any_full), .idx(full_idx));
  stc_first_set #(.N(ENTRIES)) u_part (.vec(part_vec), .any(any_part), .idx(part_idx));

  assign accept = srch_en && !busy;

  always_comb begin
    if (any_full)      cls = CLS_FULL;
    else if (any_part) cls = CLS_PART;
    else               cls = CLS_NONE;
  end

  // Backup-check capture
  logic [TAG_W-1:0]  bk_key;
  logic [HALF_W-1:0] bk_lo, bk_mix;
  logic [IDX_W-1:0]  bk_idx;
  logic              bk_equal;

  assign bk_equal = (rebuild(bk_lo, bk_mix) == bk_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_idx    <= '0;
      rsp_backup <= 1'b0;
      bk_key     <= '0;
      bk_lo      <= '0;
      bk_mix     <= '0;
      bk_idx     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (busy) begin
        busy       <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_backup <= 1'b1;
        rsp_hit    <= bk_equal;
        rsp_idx    <= bk_idx;
      end else if (accept) begin
        unique case (cls)
          CLS_FULL: begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_backup <= 1'b0;
            rsp_idx    <= full_idx;
          end
          CLS_PART: begin
            busy   <= 1'b1;
            bk_key <= srch_key;
            bk_lo  <= st_lo[part_idx];
            bk_mix <= st_mix[part_idx];
            bk_idx <= part_idx;
          end
          default: begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_backup <= 1'b0;
            rsp_idx    <= '0;
          end
        endcase
      end
    end
  end

  assign rd_tag   = rebuild(st_lo[rd_idx], st_mix[rd_idx]);
  assign rd_valid = st_valid[rd_idx];
endmodule

// File: rtl/split_tag_cam_chk.sv
module split_tag_cam_chk (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic srch_en,
  input logic any_full,
  input logic any_part,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_backup
);
  // R4
  full_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && any_full |=> rsp_valid && rsp_hit && !rsp_backup && !busy);

  // R5
  part_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !any_full && any_part |=> busy && !rsp_valid);

  // R5
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && rsp_valid && rsp_backup);

  // R5
  backup_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_backup |-> !rsp_hit);

  // R6
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !any_full && !any_part |=> rsp_valid && !rsp_hit && !rsp_backup);

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && srch_en |=> rsp_backup);

  // R10
  pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !busy |=> !rsp_valid);
endmodule

bind split_tag_cam split_tag_cam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .srch_en(srch_en),
  .any_full(any_full), .any_part(any_part), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_backup(rsp_backup)
);

// File: tb/tb_split_tag_cam.sv
module tb_split_tag_cam;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, srch_en = 1'b0;
  logic [3:0]  wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_tag = '0, srch_key = '0;
  logic        busy, rsp_valid, rsp_hit, rsp_backup, rd_valid;
  logic [3:0]  rsp_idx;
  logic [15:0] rd_tag;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [15:0] m_tag [N];
  bit          m_v   [N];

  split_tag_cam dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // Bench-side classification: 0 none, 1 full, 2 partial.
  function automatic int classify(input logic [15:0] key, output int idx);
    int fi = -1, pi = -1;
    for (int e = 0; e < N; e++) begin
      bit a, b;
      if (!m_v[e]) continue;
      a = (key[7:0] == m_tag[e][7:0]);
      b = ((key[15:8] ^ key[7:0]) == (m_tag[e][15:8] ^ m_tag[e][7:0]));
      if (a && b && fi < 0) fi = e;
      if ((a != b) && pi < 0) pi = e;
    end
    if (fi >= 0) begin idx = fi; return 1; end
    if (pi >= 0) begin idx = pi; return 2; end
    idx = 0;
    return 0;
  endfunction

  task automatic do_write(input int idx, input logic [15:0] tag, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_tag = tag; wr_valid = v;
    @(posedge clk);
    m_tag[idx] = tag; m_v[idx] = v;
    @(negedge clk);
    wr_en = 1'b0;
    rd_idx = 4'(idx);
    #1;
    chk(rd_tag == tag, "R2 rd_tag", int'(rd_tag), int'(tag));
    chk(rd_valid == v, "R2/R9 rd_valid", int'(rd_valid), int'(v));
  endtask

  // Drives a search and checks the response; with intrude=1 also offers a
  // hitting key during the busy cycle (R8).
  task automatic do_search(input logic [15:0] key, input bit intrude);
    int ei, ek;
    ek = classify(key, ei);
    @(negedge clk);
    srch_en = 1'b1; srch_key = key;
    @(posedge clk);
    @(negedge clk);
    srch_en = 1'b0;
    if (ek == 2) begin
      chk(busy == 1'b1 && rsp_valid == 1'b0, "R5 busy cycle", int'({busy, rsp_valid}), 2);
      if (intrude) begin
        srch_en = 1'b1;
        srch_key = m_v[0] ? m_tag[0] : key;
      end
      @(posedge clk);
      @(negedge clk);
      srch_en = 1'b0;
      chk(busy == 1'b0 && rsp_valid && rsp_backup && !rsp_hit,
          "R5 backup result", int'({busy, rsp_valid, rsp_backup, rsp_hit}), 4'b0110);
      chk(rsp_idx == 4'(ei), "R5 backup idx", int'(rsp_idx), ei);
      if (intrude) begin
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && busy == 1'b0, "R8 ignored during busy",
            int'({rsp_valid, busy}), 0);
      end
    end else if (ek == 1) begin
      chk(rsp_valid && rsp_hit && !rsp_backup && !busy, "R4 full hit",
          int'({rsp_valid, rsp_hit, rsp_backup, busy}), 4'b1100);
      chk(rsp_idx == 4'(ei), "R4 lowest idx", int'(rsp_idx), ei);
    end else begin
      chk(rsp_valid && !rsp_hit && !rsp_backup && !busy && rsp_idx == 0, "R6/R7 miss",
          int'({rsp_valid, rsp_hit, rsp_backup, busy, rsp_idx}), 8'b1000_0000);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < N; e++) begin m_tag[e] = '0; m_v[e] = 1'b0; end
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(busy == 0 && rsp_valid == 0, "R1 outputs idle", int'({busy, rsp_valid}), 0);
    for (int e = 0; e < N; e++) begin
      rd_idx = 4'(e); #1;
      chk(rd_valid == 0 && rd_tag == 0, "R1 entry empty", int'({rd_valid, rd_tag}), 0);
    end
    rst_n = 1'b1;
    do_search(16'h12AB, 1'b0);               // R1/R6 nothing stored
    do_write(3, 16'h12AB, 1'b1);
    do_search(16'h12AB, 1'b0);               // R4
    do_write(5, 16'h12AB, 1'b1);
    do_search(16'h12AB, 1'b0);               // R4 lowest index 3
    do_search(16'h34AB, 1'b0);               // R3 low bank only -> R5
    do_search(16'h15AC, 1'b0);               // R3 mixed bank only -> R5
    do_search(16'h0000, 1'b0);               // R6
    do_write(0, 16'h7777, 1'b1);
    do_search(16'h34AB, 1'b1);               // R8 hit key offered while busy
    do_write(3, 16'h12AB, 1'b0);             // R9
    do_search(16'h12AB, 1'b0);               // now entry 5
    do_write(5, 16'h12AB, 1'b0);
    do_search(16'h12AB, 1'b0);               // R7 invalid entries ignored
    do_search(16'h34AB, 1'b0);               // R7 no partial from invalid
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 9));
      int e   = int'($urandom_range(0, N - 1));
      logic [15:0] k;
      if (sel < 3) begin
        do_write(e, {4'h0, 4'($urandom), 8'($urandom_range(0, 7))}, ($urandom_range(0, 4) != 0));
      end else begin
        if (sel < 6)      k = m_tag[e];
        else if (sel < 8) k = {8'($urandom), m_tag[e][7:0]};
        else              k = {4'h0, 4'($urandom), 8'($urandom_range(0, 7))};
        do_search(k, sel == 9);
      end
    end
    summary();
  end
endmodule